// File: doc/BRIEF.md
# Manchester Frame Sync Receiver

This block takes the serial bit stream delivered by a radio receiver, one bit per strobe (each strobe marks a rising edge of the recovered clock), and packs it into raw bytes. After it is armed it lets a fixed number of preamble bytes pass without looking at them. It then hunts for a programmable two-byte synchronisation word, which may begin at any bit position inside a raw byte.

When the first sync byte is found, the block records the bit shift at which it matched and uses that shift for every later byte. The byte that follows must equal the second sync byte. If it does not, the hunt starts again. After a confirmed sync the block reads Manchester-coded bytes in pairs. Each coded byte gives one nibble, and the pair gives one payload byte. It counts out a fixed payload length, flags payload bytes that carry an invalid bit pair, and returns to idle. If no sync is confirmed within a programmable number of raw bytes, it reports sync loss and goes idle.

Top module: `mframe_sync_rx`

## Requirements
- R1: After reset `busy`, `out_valid`, `out_err`, `frame_done` and `sync_lost` are 0. While idle, bits on `bit_in` produce no output and leave `busy` at 0. A one-cycle `arm` pulse in idle starts reception and sets `busy`.
- R2: The first PREAMBLE_BYTES raw bytes after arming (8 bits each, first bit in the MSB) are never searched. A sync word inside them does not lock. The first searched window is raw bytes PREAMBLE_BYTES+1 and PREAMBLE_BYTES+2.
- R3: At each raw byte the search window is the last two raw bytes (16 bits, older byte first). The block tries shifts 0 to 7 and takes the lowest shift whose 8 bits equal `sync_a`. That shift sets the alignment of every later byte, so sync is found at any bit offset.
- R4: Once `sync_a` is found, the next aligned byte is compared with `sync_b`. On a mismatch the hunt restarts with the following raw byte, with no output.
- R5: Each aligned coded byte holds four bit pairs, MSB first. Pair 10 decodes to 1 and pair 01 decodes to 0. The first coded byte of a pair gives the upper nibble and the second gives the lower nibble. The payload byte is presented on `out_byte` with a one-cycle `out_valid`.
- R6: A pair of 00 or 11 decodes to its first bit. It raises `out_err` together with `out_valid` for that payload byte only, and reception continues.
- R7: A frame delivers exactly PAYLOAD_COUNT+1 payload bytes. `frame_done` pulses for one cycle together with the last `out_valid`. `busy` then falls, and later bits produce no output.
- R8: Each raw byte handled while hunting or checking `sync_b` is a search byte. At the first search byte numbered `search_limit` or later that neither finds `sync_a` nor confirms `sync_b`, `sync_lost` pulses for one cycle and `busy` falls.
- R9: `sync_a` and `sync_b` are inputs. Any pair of values that does not occur by chance in the stream locks correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start reception from idle |
| bit_valid | input | 1 | One received bit is present on `bit_in` |
| bit_in | input | 1 | Received bit |
| sync_a | input | 8 | First sync byte |
| sync_b | input | 8 | Second sync byte |
| search_limit | input | LIMIT_W | Maximum number of search bytes |
| busy | output | 1 | Reception in progress |
| out_byte | output | 8 | Decoded payload byte |
| out_valid | output | 1 | `out_byte` is valid |
| out_err | output | 1 | Invalid Manchester pair in this byte |
| frame_done | output | 1 | Last payload byte delivered |
| sync_lost | output | 1 | Search limit reached without sync |

## Verification
Every result is registered. `out_valid`, `out_err` and `frame_done` appear in the cycle after the clock edge that takes the last bit of the raw byte completing the second coded byte of a pair. `sync_lost` appears in the cycle after the edge that completes the failing search byte. The bench drives bits at falling edges and records outputs at falling edges, so each result is read half a cycle after the edge that makes it. The timeout test reads `busy` and the sync-loss count after the byte just before the limit and again after the limit byte, which pins the loss to one exact raw byte.

// File: rtl/mframe_sync_rx.sv
module mframe_sync_rx #(
  parameter int PREAMBLE_BYTES = 24,
  parameter int PAYLOAD_COUNT  = 84,
  parameter int LIMIT_W        = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               bit_valid,
  input  logic               bit_in,
  input  logic [7:0]         sync_a,
  input  logic [7:0]         sync_b,
  input  logic [LIMIT_W-1:0] search_limit,
  output logic               busy,
  output logic [7:0]         out_byte,
  output logic               out_valid,
  output logic               out_err,
  output logic               frame_done,
  output logic               sync_lost
);
  localparam int PRE_W = $clog2(PREAMBLE_BYTES + 1) + 1;
  localparam int PAY_W = $clog2(PAYLOAD_COUNT + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_SKIP, S_HUNT, S_CHECK, S_DATA} state_t;
  state_t state;

  logic [15:0]        win;
  logic [2:0]         bit_cnt, shift_k, hk;
  logic [PRE_W-1:0]   skip_cnt;
  logic [LIMIT_W-1:0] scnt;
  logic [PAY_W-1:0]   pay_cnt;
  logic               lo_next, hi_err, hit;
  logic [3:0]         hi_nib;

  function automatic logic [7:0] pick(input logic [15:0] w, input logic [2:0] k);
    logic [15:0] t;
    t = w << k;
    return t[15:8];
  endfunction

  wire [15:0]      win_nx    = {win[14:0], bit_in};
  wire             byte_tick = bit_valid && (state != S_IDLE) && (bit_cnt == 3'd7);
  wire [7:0]       aligned   = pick(win_nx, shift_k);
  wire [LIMIT_W:0] scnt_nx   = {1'b0, scnt} + 1'b1;
  wire             expired   = scnt_nx >= {1'b0, search_limit};

  logic [3:0] nib;
  logic       nib_err;
  always_comb begin
    nib_err = 1'b0;
    for (int i = 0; i < 4; i++) begin
      nib[3-i] = aligned[7-2*i];
      if (aligned[7-2*i] == aligned[6-2*i]) nib_err = 1'b1;
    end
  end

  always_comb begin
    hit = 1'b0;
    hk  = '0;
    for (int k = 7; k >= 0; k--)
      if (pick(win_nx, 3'(k)) == sync_a) begin
        hit = 1'b1;
        hk  = 3'(k);
      end
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      win        <= '0;
      bit_cnt    <= '0;
      shift_k    <= '0;
      skip_cnt   <= '0;
      scnt       <= '0;
      pay_cnt    <= '0;
      lo_next    <= 1'b0;
      hi_err     <= 1'b0;
      hi_nib     <= '0;
      out_byte   <= '0;
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      frame_done <= 1'b0;
      sync_lost  <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      frame_done <= 1'b0;
      sync_lost  <= 1'b0;
      if (state == S_IDLE) begin
        if (arm) begin
          state    <= S_SKIP;
          bit_cnt  <= '0;
          skip_cnt <= '0;
          scnt     <= '0;
        end
      end else if (bit_valid) begin
        win     <= win_nx;
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_tick) begin
        case (state)
          S_SKIP: begin
            skip_cnt <= skip_cnt + 1'b1;
            if (skip_cnt == PRE_W'(PREAMBLE_BYTES)) state <= S_HUNT;
          end
          S_HUNT: begin
            scnt <= scnt_nx[LIMIT_W-1:0];
            if (hit) begin
              shift_k <= hk;
              state   <= S_CHECK;
            end else if (expired) begin
              sync_lost <= 1'b1;
              state     <= S_IDLE;
            end
          end
          S_CHECK: begin
            scnt <= scnt_nx[LIMIT_W-1:0];
            if (aligned == sync_b) begin
              state   <= S_DATA;
              pay_cnt <= PAY_W'(PAYLOAD_COUNT);
              lo_next <= 1'b0;
            end else if (expired) begin
              sync_lost <= 1'b1;
              state     <= S_IDLE;
            end else begin
              state <= S_HUNT;
            end
          end
          S_DATA: begin
            if (!lo_next) begin
              hi_nib  <= nib;
              hi_err  <= nib_err;
              lo_next <= 1'b1;
            end else begin
              lo_next   <= 1'b0;
              out_byte  <= {hi_nib, nib};
              out_err   <= hi_err | nib_err;
              out_valid <= 1'b1;
              if (pay_cnt == '0) begin
                frame_done <= 1'b1;
                state      <= S_IDLE;
              end else begin
                pay_cnt <= pay_cnt - 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mframe_sync_rx_chk.sv
module mframe_sync_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic out_valid,
  input logic out_err,
  input logic frame_done,
  input logic sync_lost
);
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !out_valid);

  assert_err_with_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  assert_done_on_last_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> out_valid);

  assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!busy && !frame_done));

  assert_lost_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> (!out_valid && !frame_done));

  assert_idle_after_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> (!busy && !sync_lost));
endmodule

bind mframe_sync_rx mframe_sync_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
  .out_err(out_err), .frame_done(frame_done), .sync_lost(sync_lost)
);

// File: tb/mframe_sync_rx_bench.sv
module mframe_sync_rx_bench;
  localparam int PRE = 24;
  localparam int NPAY = 85;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic [7:0] sync_a = 8'h2D, sync_b = 8'hD4;
  logic [15:0] search_limit = 16'd40;
  logic busy, out_valid, out_err, frame_done, sync_lost;
  logic [7:0] out_byte;

  int checks = 0, errors = 0;
  int mon_n = 0, done_cnt = 0, done_at = 0, lost_cnt = 0;
  logic [7:0] got [1024];
  logic       gerr[1024];

  always #5 clk = ~clk;

  mframe_sync_rx u_mframe_sync_rx (
    .clk(clk), .rst_n(rst_n), .arm(arm), .bit_valid(bit_valid), .bit_in(bit_in),
    .sync_a(sync_a), .sync_b(sync_b), .search_limit(search_limit), .busy(busy),
    .out_byte(out_byte), .out_valid(out_valid), .out_err(out_err),
    .frame_done(frame_done), .sync_lost(sync_lost)
  );

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      got[mon_n % 1024]  = out_byte;
      gerr[mon_n % 1024] = out_err;
      mon_n++;
    end
    if (frame_done) begin
      done_cnt++;
      done_at = mon_n;
    end
    if (sync_lost) lost_cnt++;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
    end
  endtask

  task automatic push_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = b;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) push_bit(v[i]);
  endtask

  function automatic logic [7:0] enc(input logic [3:0] n);
    logic [7:0] c;
    for (int i = 0; i < 4; i++) c[7-2*i -: 2] = n[3-i] ? 2'b10 : 2'b01;
    return c;
  endfunction

  function automatic logic [7:0] pay(input int i);
    return 8'(i * 29 + 7);
  endfunction

  task automatic do_arm();
    @(negedge clk);
    bit_valid = 1'b0;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic send_preamble();
    for (int i = 0; i < PRE; i++) send_byte(8'hAA);
  endtask

  task automatic send_sync_lead(input int off);
    send_byte(8'hAA);
    for (int i = 0; i < off; i++) push_bit(i % 2 == 0);
    send_byte(sync_a);
  endtask

  task automatic send_payload(input int err_idx);
    for (int i = 0; i < NPAY; i++) begin
      logic [7:0] lo;
      send_byte(enc(pay(i) >> 4));
      lo = enc(pay(i) & 8'h0F);
      if (i == err_idx) lo[1:0] = 2'b11;
      send_byte(lo);
    end
    send_byte(8'hAA);
    idle_cycles(3);
  endtask

  task automatic check_frame(input int b, input int bd, input int bl, input int err_idx, input string tag);
    int bad_val = 0, bad_err = 0;
    chk(mon_n - b == NPAY, {tag, " R7 payload byte count"}, mon_n - b, NPAY);
    for (int i = 0; i < NPAY && i < mon_n - b; i++) begin
      if (i != err_idx && got[(b + i) % 1024] != pay(i)) bad_val++;
      if (gerr[(b + i) % 1024] != (i == err_idx)) bad_err++;
    end
    chk(bad_val == 0, {tag, " R3 R5 decoded bytes"}, bad_val, 0);
    chk(bad_err == 0, {tag, " R6 error flags"}, bad_err, 0);
    chk(done_cnt - bd == 1, {tag, " R7 frame_done count"}, done_cnt - bd, 1);
    chk(done_at == b + NPAY, {tag, " R7 frame_done on last byte"}, done_at - b, NPAY);
    chk(busy == 1'b0, {tag, " R7 busy cleared"}, busy, 0);
    chk(lost_cnt == bl, {tag, " R8 no sync loss"}, lost_cnt - bl, 0);
    for (int i = 0; i < 4; i++) send_byte(enc(4'h5));
    idle_cycles(3);
    chk(mon_n - b == NPAY, {tag, " R7 bits after frame ignored"}, mon_n - b, NPAY);
  endtask

  task automatic t_reset();
    int b;
    chk(!busy && !out_valid && !out_err && !frame_done && !sync_lost, "R1 reset state",
        {busy, out_valid, out_err, frame_done, sync_lost}, 0);
    b = mon_n;
    for (int i = 0; i < 40; i++) push_bit(i % 3 == 0);
    idle_cycles(3);
    chk(busy == 1'b0, "R1 idle bits keep busy low", busy, 0);
    chk(mon_n == b, "R1 idle bits give no output", mon_n - b, 0);
    do_arm();
    chk(busy == 1'b1, "R1 arm sets busy", busy, 1);
  endtask

  task automatic t_frame(input logic [7:0] sa, input logic [7:0] sb, input int off,
                         input int err_idx, input string tag);
    int b, bd, bl;
    sync_a = sa;
    sync_b = sb;
    search_limit = 16'd40;
    b = mon_n; bd = done_cnt; bl = lost_cnt;
    if (!busy) do_arm();
    send_preamble();
    send_sync_lead(off);
    send_byte(sync_b);
    send_payload(err_idx);
    check_frame(b, bd, bl, err_idx, tag);
  endtask

  task automatic t_resync();
    int b, bd, bl;
    sync_a = 8'h2D;
    sync_b = 8'hD4;
    search_limit = 16'd40;
    b = mon_n; bd = done_cnt; bl = lost_cnt;
    do_arm();
    send_preamble();
    send_sync_lead(2);
    send_byte(8'h00);
    send_byte(8'hAA);
    idle_cycles(3);
    chk(mon_n == b, "R4 no output after sync_b mismatch", mon_n - b, 0);
    chk(busy == 1'b1, "R4 search continues after mismatch", busy, 1);
    send_byte(sync_a);
    send_byte(sync_b);
    send_payload(-1);
    check_frame(b, bd, bl, -1, "R4 resync");
  endtask

  task automatic t_preamble_timeout();
    int b, bl;
    sync_a = 8'h2D;
    sync_b = 8'hD4;
    search_limit = 16'd6;
    b = mon_n; bl = lost_cnt;
    do_arm();
    for (int i = 0; i < PRE; i++) send_byte((i == 10) ? sync_a : (i == 11) ? sync_b : 8'hAA);
    for (int i = 0; i < 6; i++) send_byte(8'hAA);
    idle_cycles(3);
    chk(mon_n == b, "R2 sync inside preamble not locked", mon_n - b, 0);
    chk(busy == 1'b1, "R8 still searching before limit", busy, 1);
    chk(lost_cnt == bl, "R8 no loss before limit", lost_cnt - bl, 0);
    send_byte(8'hAA);
    idle_cycles(3);
    chk(lost_cnt - bl == 1, "R8 sync_lost at limit", lost_cnt - bl, 1);
    chk(busy == 1'b0, "R8 idle after sync loss", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame(8'h2D, 8'hD4, 0, -1, "R3 offset0");
    t_frame(8'h2D, 8'hD4, 3, 10, "R6 offset3");
    t_frame(8'h96, 8'h3C, 7, -1, "R9 offset7");
    t_frame(8'h2D, 8'hD4, 5, 84, "R3 offset5");
    t_resync();
    t_preamble_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule